// File: doc/BRIEF.md
# Eight-Point Saturating Inverse DCT Core

This block computes one row or column of an inverse discrete cosine transform. It takes eight signed 16-bit coefficients and returns eight signed 16-bit samples. The work is done by a fixed four-stage butterfly network. Each multiply in the network is a Q15 multiply with rounding, followed by an accumulate and saturation. Each plain add and subtract also clamps to the signed 16-bit range. The result therefore matches, bit for bit, a software implementation that uses the same saturating vector operations.

Lane k of a bus occupies bits [16k+15:16k]. A vector is accepted on any clock edge where `in_valid` is high. The result appears on `out_coef`, with `out_valid` high, exactly two clocks later. The first register sits after stages one and two, and the second sits after stages three and four. Prescaling of the coefficients, transposition and the sequencing over two dimensions belong to the wrapper that instantiates this core.

Top module: `idct8_core`

## Requirements
- R1: While `rst` is high at a rising edge, both pipeline registers clear. After reset, `out_valid` is 0 and every output lane is 0.
- R2: `out_valid` equals the value `in_valid` had two rising edges earlier, once two edges have passed since reset.
- R3: For a vector accepted with `in_valid` high, the eight output lanes two edges later equal the saturating butterfly model, bit for bit. Lane k is bits [16k+15:16k].
- R4: A Q15 multiply-accumulate gives sat16(((k*x + 16384) >>> 15) + c). It uses a 32-bit signed product and an arithmetic shift. The constants are 23170, 13573, 6518 and 21895, plus the separate negatives -23170 and -21895.
- R5: Every add and subtract clamps to [-32768, 32767]. The negation 0 - (-32768) yields 32767.
- R6: An all-zero input vector yields an all-zero output vector.
- R7: With `in_valid` low, the pipeline data does not change. `out_coef` keeps its last value until a new valid vector reaches it.
- R8: An input whose lanes 1 to 7 are zero yields eight output lanes that all equal lane 0 of the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector qualifier |
| in_coef | input | 128 | Eight signed 16-bit coefficients, lane k at [16k+15:16k] |
| out_valid | output | 1 | Output vector qualifier, two clocks after `in_valid` |
| out_coef | output | 128 | Eight signed 16-bit results, lane k at [16k+15:16k] |

## Verification
The network has no feedback, so any fault in a stage is visible at the ports two clocks after the first vector that exercises it. A corrupted value in the middle register shows up one clock later on the lanes that depend on it. A rounding or clamping fault appears only when values approach full scale. For that reason, extreme inputs of ±32767 and -32768 are mixed with random ones. A load enable that fires while the input is idle breaks the hold of `out_coef`, which is compared on every clock including idle ones.

// File: rtl/idct8_pkg.sv
package idct8_pkg;

    localparam int SMP_W    = 16;
    localparam int N_LANES  = 8;
    localparam int PROD_W   = 2 * SMP_W;
    localparam int Q_SHIFT  = SMP_W - 1;
    localparam int BUS_W    = N_LANES * SMP_W;

    typedef logic signed [SMP_W-1:0]  smp_t;
    typedef logic signed [PROD_W-1:0] wide_t;
    typedef logic [N_LANES-1:0][SMP_W-1:0] bus_t;

    localparam smp_t SMP_MAX = smp_t'((1 << (SMP_W - 1)) - 1);
    localparam smp_t SMP_MIN = smp_t'(-(1 << (SMP_W - 1)));
    localparam wide_t RND    = wide_t'(1) <<< (Q_SHIFT - 1);

    // Butterfly rotation constants (Q15)
    localparam smp_t K_C4  = smp_t'(23170);
    localparam smp_t K_A0  = smp_t'(13573);
    localparam smp_t K_A1  = smp_t'(6518);
    localparam smp_t K_A2  = smp_t'(21895);
    localparam smp_t K_NC4 = smp_t'(-23170);
    localparam smp_t K_NA2 = smp_t'(-21895);

    // Values carried between the first and second half of the network
    typedef struct packed {
        smp_t e_sum;   // even sum path
        smp_t e_dif;   // even difference path
        smp_t e_rot;   // rotated even pair, plus
        smp_t e_rtn;   // rotated even pair, minus
        smp_t o_sum;   // odd outer sum
        smp_t o_dif;   // odd outer difference
        smp_t o_isum;  // odd inner sum
        smp_t o_idif;  // odd inner difference
    } mid_t;

    function automatic smp_t clamp16(input wide_t v);
        if (v > wide_t'(SMP_MAX))      return SMP_MAX;
        else if (v < wide_t'(SMP_MIN)) return SMP_MIN;
        else                           return smp_t'(v);
    endfunction

    function automatic smp_t sadd(input smp_t a, input smp_t b);
        wide_t s;
        s = wide_t'(a) + wide_t'(b);
        return clamp16(s);
    endfunction

    function automatic smp_t ssub(input smp_t a, input smp_t b);
        wide_t s;
        s = wide_t'(a) - wide_t'(b);
        return clamp16(s);
    endfunction

    // Q15 product with rounding, then accumulate and clamp
    function automatic smp_t qmac(input smp_t k, input smp_t x, input smp_t c);
        wide_t p;
        p = wide_t'(k) * wide_t'(x);
        p = (p + RND) >>> Q_SHIFT;
        p = p + wide_t'(c);
        return clamp16(p);
    endfunction

endpackage

// File: rtl/idct8_front.sv
module idct8_front
    import idct8_pkg::*;
(
    input  bus_t x_bus,
    output mid_t mid
);
    smp_t x [N_LANES];

    for (genvar g = 0; g < N_LANES; g++) begin : g_unpack
        assign x[g] = smp_t'(x_bus[g]);
    end

    smp_t s1_p, s1_q, s1_r, s1_s;

    always_comb begin
        // stage one: odd rotations
        s1_p = qmac(K_A1,  x[7], x[1]);
        s1_q = qmac(K_A1,  x[1], ssub(smp_t'(0), x[7]));
        s1_r = qmac(K_A2,  x[5], x[3]);
        s1_s = qmac(K_NA2, x[3], x[5]);
        // stage two: even butterflies and odd recombination
        mid.e_sum  = sadd(x[0], x[4]);
        mid.e_dif  = ssub(x[0], x[4]);
        mid.e_rot  = qmac(K_A0, x[6], x[2]);
        mid.e_rtn  = qmac(K_A0, x[2], ssub(smp_t'(0), x[6]));
        mid.o_isum = sadd(s1_q, s1_s);
        mid.o_idif = ssub(s1_q, s1_s);
        mid.o_dif  = ssub(s1_p, s1_r);
        mid.o_sum  = sadd(s1_p, s1_r);
    end

    // R6: zero in gives zero at the midpoint
    always_comb begin
        if (x_bus == '0)
            assert_zero_front_R6: assert (mid == '0)
                else $error("front stage: zero input produced non-zero midpoint");
    end

endmodule

// File: rtl/idct8_back.sv
module idct8_back
    import idct8_pkg::*;
(
    input  mid_t mid,
    output bus_t y_bus
);
    smp_t y [N_LANES];
    smp_t u_ev_p, u_ev_m, u_od_p, u_od_m, v_rot_m, v_rot_p;

    always_comb begin
        // stage three
        u_ev_p  = sadd(mid.e_sum, mid.e_rot);
        u_ev_m  = ssub(mid.e_sum, mid.e_rot);
        u_od_p  = sadd(mid.e_dif, mid.e_rtn);
        u_od_m  = ssub(mid.e_dif, mid.e_rtn);
        v_rot_m = ssub(mid.o_dif, mid.o_idif);
        v_rot_p = sadd(mid.o_dif, mid.o_idif);
        // stage four
        y[0] = sadd(u_ev_p, mid.o_sum);
        y[7] = ssub(u_ev_p, mid.o_sum);
        y[1] = qmac(K_C4,  v_rot_p, u_od_p);
        y[6] = qmac(K_NC4, v_rot_p, u_od_p);
        y[2] = qmac(K_C4,  v_rot_m, u_od_m);
        y[5] = qmac(K_NC4, v_rot_m, u_od_m);
        y[3] = sadd(u_ev_m, mid.o_isum);
        y[4] = ssub(u_ev_m, mid.o_isum);
    end

    for (genvar g = 0; g < N_LANES; g++) begin : g_pack
        assign y_bus[g] = y[g];
    end

    // R6: zero midpoint gives zero output
    always_comb begin
        if (mid == '0)
            assert_zero_back_R6: assert (y_bus == '0)
                else $error("back stage: zero midpoint produced non-zero output");
    end

endmodule

// File: rtl/idct8_stage_reg.sv
module idct8_stage_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (ld) q <= d;
    end

    // R7: an unloaded register holds its value
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(q))
        else $error("stage register changed without load");

endmodule

// File: rtl/idct8_core.sv
module idct8_core
    import idct8_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [BUS_W-1:0]      in_coef,
    output logic                  out_valid,
    output logic [BUS_W-1:0]      out_coef
);
    localparam int MID_W = $bits(mid_t);

    bus_t            x_bus, y_bus;
    mid_t            mid_d, mid_q;
    logic [MID_W-1:0] mid_qv;
    logic            mid_valid;

    assign x_bus = in_coef;

    idct8_front u_front (.x_bus(x_bus), .mid(mid_d));

    idct8_stage_reg #(.W(MID_W)) u_mid_reg (
        .clk(clk), .rst(rst), .ld(in_valid), .d(mid_d), .q(mid_qv)
    );
    assign mid_q = mid_t'(mid_qv);

    idct8_back u_back (.mid(mid_q), .y_bus(y_bus));

    idct8_stage_reg #(.W(BUS_W)) u_out_reg (
        .clk(clk), .rst(rst), .ld(mid_valid), .d(y_bus), .q(out_coef)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mid_valid <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            mid_valid <= in_valid;
            out_valid <= mid_valid;
        end
    end

    // ---- checking support: edges since reset, capped at two ----
    logic [1:0] warm_cnt;
    logic       dc_in;
    always_ff @(posedge clk) begin
        if (rst)                 warm_cnt <= 2'd0;
        else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
    end
    assign dc_in = (in_coef[BUS_W-1:SMP_W] == '0);

    assert_valid_lat_R2: assert property (@(posedge clk) disable iff (rst)
        (warm_cnt == 2'd2) |-> (out_valid == $past(in_valid, 2)))
        else $error("out_valid does not follow in_valid by two clocks");

    assert_dc_flat_R8: assert property (@(posedge clk) disable iff (rst)
        (warm_cnt == 2'd2 && $past(in_valid, 2) && $past(dc_in, 2)) |->
        (out_coef == {N_LANES{$past(in_coef[SMP_W-1:0], 2)}}))
        else $error("DC-only input did not give flat output");

    assert_out_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !mid_valid |=> $stable(out_coef))
        else $error("out_coef moved with no valid vector arriving");

endmodule

// File: tb/idct8_core_bench.sv
module idct8_core_bench;
    localparam int NL = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] in_coef;
    logic         out_valid;
    logic [127:0] out_coef;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";
    bit    started = 0;
    bit    done = 0;

    // behavioural model state
    bit mv, ov;
    int md [NL];
    int od [NL];

    always #10 clk = ~clk;

    idct8_core u_idct8_core (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_coef(in_coef),
        .out_valid(out_valid), .out_coef(out_coef)
    );

    function automatic int lim(int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int rm(int k, int x, int c);
        return lim(((k * x + 16384) >>> 15) + c);
    endfunction

    function automatic void model(input int x [NL], output int y [NL]);
        int p, q, r, s, es, ed, er, en, os, od2, ois, oid, a, b, c, d, e, f;
        p   = rm(6518, x[7], x[1]);
        q   = rm(6518, x[1], lim(-x[7]));
        r   = rm(21895, x[5], x[3]);
        s   = rm(-21895, x[3], x[5]);
        es  = lim(x[0] + x[4]);
        ed  = lim(x[0] - x[4]);
        er  = rm(13573, x[6], x[2]);
        en  = rm(13573, x[2], lim(-x[6]));
        ois = lim(q + s);
        oid = lim(q - s);
        od2 = lim(p - r);
        os  = lim(p + r);
        a = lim(es + er); b = lim(es - er);
        c = lim(ed + en); d = lim(ed - en);
        e = lim(od2 - oid); f = lim(od2 + oid);
        y[0] = lim(a + os);  y[7] = lim(a - os);
        y[1] = rm(23170, f, c);  y[6] = rm(-23170, f, c);
        y[2] = rm(23170, e, d);  y[5] = rm(-23170, e, d);
        y[3] = lim(b + ois); y[4] = lim(b - ois);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mv = 0; ov = 0;
            foreach (md[i]) begin md[i] = 0; od[i] = 0; end
        end else begin
            ov = mv;
            if (mv) od = md;
            mv = in_valid;
            if (in_valid) begin
                int xi [NL];
                for (int i = 0; i < NL; i++) xi[i] = int'($signed(in_coef[i*16 +: 16]));
                model(xi, md);
            end
        end
        started = 1;
    end

    // compare every cycle at the falling edge
    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (out_valid !== ov) begin
                fails++;
                $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, ov);
            end
            checks++;
            for (int i = 0; i < NL; i++) begin
                int act;
                act = int'($signed(out_coef[i*16 +: 16]));
                if (act != od[i]) begin
                    fails++;
                    $display("FAIL %s lane %0d actual=%0d expected=%0d", tag, i, act, od[i]);
                    break;
                end
            end
        end
    end

    task automatic drive(input bit v, input int x [NL]);
        @(negedge clk);
        in_valid = v;
        for (int i = 0; i < NL; i++) in_coef[i*16 +: 16] = 16'(x[i]);
    endtask

    task automatic idle(input int n);
        int z [NL];
        foreach (z[i]) z[i] = 0;
        repeat (n) drive(0, z);
    endtask

    function automatic int pick_ext();
        case ($urandom % 5)
            0: return 32767;
            1: return -32768;
            2: return -32767;
            3: return 0;
            default: return int'($signed(16'($urandom)));
        endcase
    endfunction

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog expired");
                done = 1;
            end
            begin
                int v [NL];
                rst = 1; in_valid = 0; in_coef = '0;
                repeat (3) @(negedge clk);
                tag = "R1";                       // reset state checked each cycle
                rst = 0;
                idle(2);
                // R6: all-zero vector
                tag = "R6";
                foreach (v[i]) v[i] = 0;
                drive(1, v); idle(3);
                // R8: DC only
                tag = "R8";
                foreach (v[i]) v[i] = 0;
                v[0] = 1234;  drive(1, v);
                v[0] = -32768; drive(1, v);
                v[0] = 32767; drive(1, v);
                idle(3);
                // R5: saturating add paths, including 0 - (-32768)
                tag = "R5";
                foreach (v[i]) v[i] = 0;
                v[0] = 32767; v[4] = 32767; drive(1, v);
                v[0] = -32768; v[4] = 32767; drive(1, v);
                foreach (v[i]) v[i] = 0;
                v[7] = -32768; v[6] = -32768; drive(1, v);
                idle(3);
                // R4: multiply-accumulate rounding and clamp at full scale
                tag = "R4";
                for (int n = 0; n < 300; n++) begin
                    foreach (v[i]) v[i] = pick_ext();
                    drive(1, v);
                end
                idle(3);
                // R3 and R7: random data with gaps in valid
                tag = "R3";
                for (int n = 0; n < 2000; n++) begin
                    foreach (v[i]) v[i] = int'($signed(16'($urandom)));
                    drive(($urandom % 3) != 0, v);
                end
                tag = "R7";                       // inputs toggle while invalid
                for (int n = 0; n < 50; n++) begin
                    foreach (v[i]) v[i] = int'($signed(16'($urandom)));
                    drive(0, v);
                end
                // R2/R1: reset in mid-stream clears pipeline
                tag = "R1";
                foreach (v[i]) v[i] = 777;
                drive(1, v);
                rst = 1;
                idle(2);
                rst = 0;
                idle(3);
                done = 1;
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule